// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that gives a host read and write access to a bank of eight 8-bit configuration registers. The serial pins are brought into the core clock domain through synchronizers, and the edges of the serial clock are detected there. Every transaction is 16 bits long and both fields travel least significant bit first. The first byte is a control byte that carries a direction flag and a register address. The second byte is either write data taken from the data input, or the addressed register's contents driven on the data output.

Access needs the framing qualifier held high and the active-low select held low. If either is withdrawn, the bit counter and the captured control bits are cleared. The host may send a transaction as one continuous 16-bit word, or as two bytes with an idle stretch of the serial clock between them. When the serial clock is gated, the select may stay low across any number of transactions. Downstream logic reads all register contents in parallel from a flat output vector.

Top module: `cfg_serial_port`

## Requirements
- R1: While rst_ni is low and after it is released, every register reads 0 on regs_o, sdo_o and sdo_oe_o are 0, and the bit counter is at zero.
- R2: Serial data is sampled on rising edges of sclk_i, LSB first. The control byte is laid out as follows: bit 0 (sent first) is 1 for read and 0 for write, and bits 3:1 hold the register address.
- R3: In a write, the next 8 bits (LSB first) replace the addressed register, on the rising edge that samples the 16th bit. No other register changes.
- R4: In a read, sdo_oe_o is 1 and sdo_o carries the addressed register LSB first, updated on each falling edge of sclk_i after the control byte. The register does not change.
- R5: Outside the read data phase, sdo_o and sdo_oe_o are 0.
- R6: If cs_ni goes high before the 16th bit, no register changes, and the next transaction starts again from bit 0.
- R7: If sync_i goes low before the 16th bit, no register changes. With sync_i low, no transfer takes place at all. Raising sync_i again restarts from bit 0.
- R8: Splitting a transaction into two bytes with an idle sclk_i gap gives the same result as an unbroken 16-bit word.
- R9: When cs_ni stays low, transactions may follow one another directly, because the counter wraps to 0 after the 16th bit.
- R10: Bits 7:4 of the control byte have no effect.
- R11: sclk_i edges while cs_ni is high have no effect on registers, outputs or framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low select |
| sync_i | input | 1 | Access qualifier, high to enable transfers |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | High while sdo_o carries read data |
| regs_o | output | 64 | All registers, register n at bits [8n+7:8n] |

## Verification
The hardest situation to reach is a transaction that is cut off partway through. It must leave every register untouched and must not shift the framing of the transaction that follows. The stimulus aborts transfers after a random number of bits, using the select in some cases and the qualifier in others, and then runs a full write and read to check the bit alignment. Byte-split transfers are mixed with back-to-back transfers under a select held low, so that counter wrap-around and the idle gap between bytes both occur between random writes and reads.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned RW_POS = 0;
  localparam int unsigned ADDR_LSB = 1;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[g]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_spi_shift.sv
module cfg_spi_shift
  import cfg_spi_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_s_i,
  input  logic          cs_ns_i,
  input  logic          sync_s_i,
  input  logic          sdi_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam int unsigned FRAME = 2 * DW;
  localparam int unsigned CNT_W = $clog2(FRAME);
  localparam int unsigned IDX_W = $clog2(DW);
  localparam int unsigned CTL_W = AW + 1;

  logic             sclk_d_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CTL_W-1:0] ctrl_q;
  logic [DW-2:0]    data_q;
  logic             sdo_q, oe_q;
  logic             active, rise, fall, in_ctrl, last;
  logic [IDX_W-1:0] idx;
  dir_e             dir;

  assign active  = sync_s_i & ~cs_ns_i;
  assign rise    = active & sclk_s_i & ~sclk_d_q;
  assign fall    = active & ~sclk_s_i & sclk_d_q;
  assign in_ctrl = cnt_q < CNT_W'(DW);
  assign last    = cnt_q == CNT_W'(FRAME - 1);
  assign idx     = cnt_q[IDX_W-1:0];
  assign dir     = dir_e'(ctrl_q[RW_POS]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s_i;
  end

  // bit counter and capture; any loss of framing discards partial state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
      data_q <= '0;
    end else if (!active) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
      data_q <= '0;
    end else if (rise) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (in_ctrl) begin
        for (int b = 0; b < CTL_W; b++)
          if (idx == IDX_W'(b)) ctrl_q[b] <= sdi_s_i;
      end else begin
        for (int b = 0; b < DW - 1; b++)
          if (idx == IDX_W'(b)) data_q[b] <= sdi_s_i;
      end
    end
  end

  // read data launched on falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (!active) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (fall) begin
      oe_q  <= (dir == DIR_READ) && !in_ctrl;
      sdo_q <= (dir == DIR_READ) && !in_ctrl && rd_data_i[idx];
    end
  end

  assign wr_en_o   = rise && last && (dir == DIR_WRITE);
  assign addr_o    = ctrl_q[ADDR_LSB +: AW];
  assign wr_data_o = {sdi_s_i, data_q};
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;

  // R6
  frame_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> cnt_q == '0);
  // R9
  wrap_after_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> cnt_q == '0);
  // R5
  oe_off_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !oe_q);
  // R5
  sdo_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> !sdo_q);
  // R4
  oe_only_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> dir == DIR_READ);
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wr_data_i,
  output logic [DW-1:0]            rd_data_o,
  output logic [(1<<AW)*DW-1:0]    regs_o
);
  localparam int unsigned NREG = 1 << AW;

  logic [NREG*DW-1:0] regs_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[r*DW +: DW] <= '0;
      else if (wr_en_i && addr_i == AW'(r))      regs_q[r*DW +: DW] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[addr_i*DW +: DW];
  assign regs_o    = regs_q;

  // R6
  hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_spi_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  cs_ni,
  input  logic                  sync_i,
  input  logic                  sdi_i,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  output logic [(1<<AW)*DW-1:0] regs_o
);
  logic [3:0]    pins_s;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data, rd_data;

  // lanes: 0 sclk, 1 cs_n, 2 sync, 3 sdi
  cfg_spi_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0010)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({sdi_i, sync_i, cs_ni, sclk_i}),
    .sync_o (pins_s)
  );

  cfg_spi_shift #(.DW(DW), .AW(AW)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (pins_s[0]),
    .cs_ns_i  (pins_s[1]),
    .sync_s_i (pins_s[2]),
    .sdi_s_i  (pins_s[3]),
    .rd_data_i(rd_data),
    .wr_en_o  (wr_en),
    .addr_o   (addr),
    .wr_data_o(wr_data),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  cfg_spi_regbank #(.DW(DW), .AW(AW)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );
endmodule

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  localparam int H = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sync = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [63:0] regs;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [8];

  always #2 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n),
    .sync_i(sync), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .regs_o(regs)
  );

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int a = 0; a < 8; a++) f[a*8 +: 8] = model[a];
    return f;
  endfunction

  task automatic chk_regs(string req);
    chk(regs == model_flat(), req, regs, model_flat());
  endtask

  // one 16-bit transfer; optional idle gap after the control byte
  task automatic xfer(input logic [7:0] ctl, input logic [7:0] wd, input bit split,
                      input bit keep_cs, output logic [7:0] rd, output bit quiet_ok);
    quiet_ok = 1'b1;
    rd = '0;
    cs_n = 1'b0;
    wclk(H);
    for (int i = 0; i < 16; i++) begin
      if (split && i == 8) wclk(4 * H);
      sdi = (i < 8) ? ctl[i] : wd[i-8];
      wclk(H);
      if (i >= 8 && ctl[0]) begin
        rd[i-8] = sdo;
        if (!sdo_oe) quiet_ok = 1'b0;
      end else if (sdo_oe || sdo) quiet_ok = 1'b0;
      sclk = 1'b1;
      wclk(H);
      sclk = 1'b0;
    end
    wclk(H);
    if (!keep_cs) begin
      cs_n = 1'b1;
      wclk(H);
    end
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d, logic [3:0] junk, bit split, string req);
    logic [7:0] rd;
    bit q;
    xfer({junk, a, 1'b0}, d, split, 1'b0, rd, q);
    model[a] = d;
    chk_regs(req);
    chk(q, "R5 quiet during write", {63'd0, q}, 64'd1);
  endtask

  task automatic do_read(logic [2:0] a, logic [3:0] junk, bit split, string req);
    logic [7:0] rd;
    bit q;
    xfer({junk, a, 1'b1}, 8'h5a, split, 1'b0, rd, q);
    chk(rd == model[a], req, {56'd0, rd}, {56'd0, model[a]});
    chk(q, "R4 oe during read data", {63'd0, q}, 64'd1);
    chk_regs("R4 read leaves registers");
  endtask

  // n bits then abort by select (mode 0) or qualifier (mode 1)
  task automatic partial(logic [7:0] ctl, logic [7:0] wd, int n, bit mode);
    cs_n = 1'b0;
    wclk(H);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 8) ? ctl[i] : wd[i-8];
      wclk(H);
      sclk = 1'b1;
      wclk(H);
      sclk = 1'b0;
    end
    wclk(H);
    if (mode) begin
      sync = 1'b0; wclk(2 * H); sync = 1'b1; wclk(H);
    end else begin
      cs_n = 1'b1; wclk(2 * H);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    bit q;
    void'($urandom(32'h5eed_c0de));
    for (int a = 0; a < 8; a++) model[a] = '0;
    wclk(3);
    // R1 during reset
    chk(regs == 64'd0 && !sdo && !sdo_oe, "R1 in reset", {regs[61:0], sdo, sdo_oe}, 64'd0);
    rst_ni = 1'b1;
    wclk(4);
    chk(regs == 64'd0 && !sdo && !sdo_oe, "R1 after reset", {regs[61:0], sdo, sdo_oe}, 64'd0);
    sync = 1'b1;
    wclk(H);

    // R2 R3 distinct value per address, then R4 read back
    for (int a = 0; a < 8; a++) do_write(3'(a), 8'(8'h81 ^ (a * 8'h13)), 4'h0, 1'b0, "R3 directed write");
    for (int a = 0; a < 8; a++) do_read(3'(a), 4'h0, 1'b0, "R4 directed read");

    // R10 junk in upper control nibble
    do_write(3'd5, 8'hc3, 4'hf, 1'b0, "R10 upper bits ignored on write");
    do_read(3'd5, 4'ha, 1'b0, "R10 upper bits ignored on read");

    // R8 split transfers
    do_write(3'd2, 8'h3c, 4'h0, 1'b1, "R8 split write");
    do_read(3'd2, 4'h0, 1'b1, "R8 split read");

    // R6 abort by select at several points
    for (int n = 1; n < 16; n += 5) begin
      partial({4'h0, 3'd1, 1'b0}, 8'hee, n, 1'b0);
      chk_regs("R6 select abort leaves registers");
    end
    partial({4'h0, 3'd1, 1'b0}, 8'hee, 15, 1'b0);
    chk_regs("R6 abort at bit 15");
    do_write(3'd1, 8'h96, 4'h0, 1'b0, "R6 aligned after abort");

    // R7 qualifier drop mid-transfer, then restart
    partial({4'h0, 3'd6, 1'b0}, 8'h11, 12, 1'b1);
    chk_regs("R7 qualifier abort leaves registers");
    do_write(3'd6, 8'h69, 4'h0, 1'b0, "R7 aligned after qualifier restart");

    // R7 whole transfer with qualifier low
    sync = 1'b0;
    wclk(H);
    xfer({4'h0, 3'd0, 1'b0}, 8'hff, 1'b0, 1'b0, rd, q);
    chk_regs("R7 no write while qualifier low");
    xfer({4'h0, 3'd0, 1'b1}, 8'h00, 1'b0, 1'b0, rd, q);
    chk(rd == 8'h00 && !sdo_oe, "R7 no read data while qualifier low", {56'd0, rd}, 64'd0);
    sync = 1'b1;
    wclk(H);

    // R11 sclk toggling with select high
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b1; wclk(H); sclk = 1'b1; wclk(H); sclk = 1'b0;
    end
    wclk(H);
    chk_regs("R11 deselected clocks ignored");
    chk(!sdo && !sdo_oe, "R11 outputs quiet", {62'd0, sdo, sdo_oe}, 64'd0);
    do_write(3'd7, 8'ha5, 4'h0, 1'b0, "R11 framing intact");

    // R9 back-to-back under a held select
    xfer({4'h0, 3'd3, 1'b0}, 8'h4b, 1'b0, 1'b1, rd, q);
    model[3] = 8'h4b;
    xfer({4'h0, 3'd4, 1'b0}, 8'hb4, 1'b0, 1'b1, rd, q);
    model[4] = 8'hb4;
    xfer({4'h0, 3'd3, 1'b1}, 8'h00, 1'b0, 1'b1, rd, q);
    cs_n = 1'b1;
    wclk(H);
    chk(rd == 8'h4b, "R9 chained read", {56'd0, rd}, 64'h4b);
    chk_regs("R9 chained writes");

    // random mix
    for (int t = 0; t < 150; t++) begin
      logic [2:0] a;
      logic [3:0] junk;
      bit split;
      a = 3'($urandom_range(0, 7));
      junk = 4'($urandom);
      split = 1'($urandom);
      case ($urandom_range(0, 4))
        0, 1: do_write(a, 8'($urandom), junk, split, "R3 random write");
        2, 3: do_read(a, junk, split, "R4 random read");
        default: begin
          partial({junk, a, 1'b0}, 8'($urandom), $urandom_range(1, 15), 1'($urandom));
          chk_regs("R6 random abort");
        end
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule